// File: doc/BRIEF.md
# Multi-Line Terminal Register Interface

This block is the register front end of an asynchronous terminal multiplexer serving up to sixteen lines. Every line owns a window of four 16-bit registers on a simple processor bus: a receive status word, a receive buffer, a transmit status word and a transmit buffer. The block decodes the bus address into a line and a register, and applies per-register read and write masks. Byte writes are merged into the current value. The block maintains the done, overrun and error-summary flags in hardware.

Received characters arrive from the serial side as a per-line strobe with an 8-bit value. Bit 7 of each character can be replaced by a generated odd or even parity bit before the character is stored. The receive status word reports the overall parity of the stored byte. A write to a line's transmit buffer clears that line's transmit done flag and starts a programmable per-line delay. When the delay runs out, the line's transmit strobe pulses and done returns. Per-line receive and transmit interrupt-request bits go to a separate interrupt block.

Top module: `term_mux_regs`

## Requirements
- R1: The register offset is bus_addr minus BASE. Offset bits [3+:log2(NLINES)] select the line, and offset bits [2:1] select the register: 0 receive status, 1 receive buffer, 2 transmit status, 3 transmit buffer. An offset at or beyond NLINES*8 reads as zero and its writes have no effect. bus_rdata is zero when bus_rd is low.
- R2: Reading receive status returns the stored value ANDed with 16'hF7FF. Reading transmit status returns its stored value ANDed with 16'h81DF. Both buffers read as a zero-extended byte.
- R3: A status write changes only the writable bits: 16'h075B for receive status and 16'h015D for transmit status. On a byte write (bus_byte=1) the byte is taken from bus_wdata[7:0]. It replaces the high byte when bus_addr[0]=1 and the low byte otherwise, and the merge happens before the mask is applied.
- R4: When receive status is read, bit 15 is returned as the OR of bits 12 to 14. The same read clears bit 7 (done) and bits 12 to 15.
- R5: A received character sets done (bit 7) when done is clear. When done is already set, it sets overrun (bit 12) instead.
- R6: par_cfg selects bit 7 of a received character. Value 1 makes the stored byte odd parity, value 2 makes it even parity, and values 0 and 3 keep the received bit 7.
- R7: Receive status bit 5 is set when the stored byte has an odd number of ones, and is cleared otherwise.
- R8: Writes to the receive buffer have no effect. A receive buffer read returns the last stored byte.
- R9: A transmit buffer write clears transmit done. A word write, or a byte write to an even address, stores bus_wdata[7:0]; a byte write to an odd address leaves the buffer unchanged. If the write happens at edge E, tx_stb for that line is high for exactly the cycle after edge E+tx_dly+1, and done is set again from that edge.
- R10: rx_irq is set by a character arrival while interrupt enable (bit 6) is set. It is also set by a status write that raises interrupt enable while done is set. It is cleared by a status write with bit 6 clear and by a receive buffer read.
- R11: tx_irq is set when the transmit delay expires with interrupt enable set. It is also set by a status write that raises interrupt enable while done is set. It is cleared by a status write with bit 6 clear and by a transmit buffer write.
- R12: After reset, receive status and both buffers read zero, transmit status reads 16'h0080, and no strobe or interrupt request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Bus byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_byte | input | 1 | Write is a single byte |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_rd is high |
| rx_stb | input | NLINES | Per-line received-character strobe |
| rx_data | input | NLINES*8 | Per-line received character, line i in bits [8i+:8] |
| par_cfg | input | 2 | Parity insertion mode |
| tx_dly | input | DLY_W | Transmit delay in cycles |
| tx_stb | output | NLINES | Per-line transmit strobe |
| tx_data | output | NLINES*8 | Per-line transmit buffer contents |
| rx_irq | output | NLINES | Per-line receive interrupt request |
| tx_irq | output | NLINES | Per-line transmit interrupt request |

## Verification
The assertions assume that the bus raises bus_rd and bus_wr one cycle at a time and never both in the same cycle. They also assume that rx_stb pulses last a single cycle. The bench drives each access in its own clock cycle, changes inputs only on the falling edge, and drops every strobe one edge later. The pulse-width property on tx_stb also relies on tx_dly being held stable while a line is counting, and the stimulus changes the delay only between transmit writes.

// File: rtl/tmx_pkg.sv
package tmx_pkg;
  localparam logic [15:0] RS_RMASK  = 16'hF7FF;
  localparam logic [15:0] RS_WMASK  = 16'h075B;
  localparam logic [15:0] TS_RMASK  = 16'h81DF;
  localparam logic [15:0] TS_WMASK  = 16'h015D;
  localparam logic [15:0] RS_STICKY = 16'hF080;
  localparam logic [15:0] TS_RESET  = 16'h0080;

  localparam int B_PAR  = 5;
  localparam int B_IE   = 6;
  localparam int B_DONE = 7;
  localparam int B_OVR  = 12;
  localparam int B_CCH  = 14;
  localparam int B_ERR  = 15;

  typedef enum logic [1:0] {
    SEL_RSTAT = 2'd0,
    SEL_RBUF  = 2'd1,
    SEL_TSTAT = 2'd2,
    SEL_TBUF  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    PAR_PASS     = 2'd0,
    PAR_ODD      = 2'd1,
    PAR_EVEN     = 2'd2,
    PAR_PASS_ALT = 2'd3
  } par_mode_e;

  function automatic logic [15:0] merge_wr(input logic [15:0] cur,
                                           input logic [15:0] wd,
                                           input logic        bw,
                                           input logic        odd);
    if (!bw)      return wd;
    else if (odd) return {wd[7:0], cur[7:0]};
    else          return {cur[15:8], wd[7:0]};
  endfunction
endpackage

// File: rtl/tmx_decode.sv
module tmx_decode #(
  parameter int          NLINES = 16,
  parameter logic [15:0] BASE   = 16'hFE00,
  localparam int         LW     = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic [15:0]        addr,
  output logic               hit,
  output logic [LW-1:0]      line,
  output tmx_pkg::reg_sel_e  sel
);
  localparam logic [15:0] SPAN = 16'(NLINES * 8);
  logic [15:0] ofs;

  assign ofs  = addr - BASE;
  assign hit  = (ofs < SPAN);
  assign line = ofs[3 +: LW];
  assign sel  = tmx_pkg::reg_sel_e'(ofs[2:1]);
endmodule

// File: rtl/tmx_parity.sv
module tmx_parity (
  input  logic [7:0]          raw,
  input  tmx_pkg::par_mode_e  mode,
  output logic [7:0]          chr,
  output logic                odd
);
  always_comb begin
    chr = raw;
    case (mode)
      tmx_pkg::PAR_ODD:  chr[7] = ~(^raw[6:0]);
      tmx_pkg::PAR_EVEN: chr[7] = ^raw[6:0];
      default:           chr[7] = raw[7];
    endcase
    odd = ^chr;
  end
endmodule

// File: rtl/tmx_line.sv
module tmx_line
  import tmx_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_rstat,
  input  logic             we_tstat,
  input  logic             we_tbuf,
  input  logic             re_rstat,
  input  logic             re_rbuf,
  input  logic             wr_byte,
  input  logic             wr_odd,
  input  logic [15:0]      wdata,
  input  logic             rx_stb,
  input  logic [7:0]       rx_chr,
  input  logic             rx_odd,
  input  logic [DLY_W-1:0] tx_dly,
  output logic [15:0]      rstat_rd,
  output logic [7:0]       rbuf,
  output logic [15:0]      tstat_rd,
  output logic [7:0]       tbuf,
  output logic             tx_stb,
  output logic             rx_irq,
  output logic             tx_irq
);
  logic [15:0]      rs_q, rs_d, ts_q, ts_d, rs_m, ts_m, rs_view;
  logic [7:0]       rb_q, rb_d, tb_q, tb_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d, stb_q, stb_d;
  logic             rirq_q, rirq_d, tirq_q, tirq_d;

  // receive side next state
  always_comb begin
    rs_m   = merge_wr(rs_q, wdata, wr_byte, wr_odd);
    rs_d   = rs_q;
    rb_d   = rb_q;
    rirq_d = rirq_q;
    if (we_rstat) begin
      rs_d = (rs_q & ~RS_WMASK) | (rs_m & RS_WMASK);
      if (!rs_m[B_IE])                       rirq_d = 1'b0;
      else if (rs_q[B_DONE] && !rs_q[B_IE])  rirq_d = 1'b1;
    end
    if (re_rstat) rs_d = rs_d & ~RS_STICKY;
    if (re_rbuf)  rirq_d = 1'b0;
    if (rx_stb) begin
      if (rs_d[B_DONE]) rs_d[B_OVR]  = 1'b1;
      else              rs_d[B_DONE] = 1'b1;
      rs_d[B_PAR] = rx_odd;
      rb_d        = rx_chr;
      if (rs_d[B_IE]) rirq_d = 1'b1;
    end
  end

  // transmit side next state
  always_comb begin
    ts_m   = merge_wr(ts_q, wdata, wr_byte, wr_odd);
    ts_d   = ts_q;
    tb_d   = tb_q;
    tirq_d = tirq_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    stb_d  = 1'b0;
    if (we_tstat) begin
      ts_d = (ts_q & ~TS_WMASK) | (ts_m & TS_WMASK);
      if (!ts_m[B_IE])                       tirq_d = 1'b0;
      else if (ts_q[B_DONE] && !ts_q[B_IE])  tirq_d = 1'b1;
    end
    if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d       = 1'b0;
        ts_d[B_DONE] = 1'b1;
        stb_d        = 1'b1;
        if (ts_d[B_IE]) tirq_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (we_tbuf) begin
      if (!wr_byte || !wr_odd) tb_d = wdata[7:0];
      ts_d[B_DONE] = 1'b0;
      tirq_d       = 1'b0;
      busy_d       = 1'b1;
      cnt_d        = tx_dly;
      stb_d        = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q   <= '0;
      rb_q   <= '0;
      ts_q   <= TS_RESET;
      tb_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      stb_q  <= 1'b0;
      rirq_q <= 1'b0;
      tirq_q <= 1'b0;
    end else begin
      rs_q   <= rs_d;
      rb_q   <= rb_d;
      ts_q   <= ts_d;
      tb_q   <= tb_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      stb_q  <= stb_d;
      rirq_q <= rirq_d;
      tirq_q <= tirq_d;
    end
  end

  always_comb begin
    rs_view        = rs_q;
    rs_view[B_ERR] = |rs_q[B_CCH:B_OVR];
  end

  assign rstat_rd = rs_view & RS_RMASK;
  assign tstat_rd = ts_q & TS_RMASK;
  assign rbuf     = rb_q;
  assign tbuf     = tb_q;
  assign tx_stb   = stb_q;
  assign rx_irq   = rirq_q;
  assign tx_irq   = tirq_q;
endmodule

// File: rtl/term_mux_regs.sv
module term_mux_regs
  import tmx_pkg::*;
#(
  parameter int          NLINES = 16,
  parameter logic [15:0] BASE   = 16'hFE00,
  parameter int          DLY_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [15:0]           bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_byte,
  input  logic                  bus_rd,
  input  logic [15:0]           bus_wdata,
  output logic [15:0]           bus_rdata,
  input  logic [NLINES-1:0]     rx_stb,
  input  logic [NLINES*8-1:0]   rx_data,
  input  logic [1:0]            par_cfg,
  input  logic [DLY_W-1:0]      tx_dly,
  output logic [NLINES-1:0]     tx_stb,
  output logic [NLINES*8-1:0]   tx_data,
  output logic [NLINES-1:0]     rx_irq,
  output logic [NLINES-1:0]     tx_irq
);
  localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1;

  logic [1:0]    rst_pipe;
  logic          rst_n_i;
  logic          hit;
  logic [LW-1:0] line;
  reg_sel_e      sel;
  par_mode_e     pmode;

  logic [15:0] rs_rd [NLINES];
  logic [15:0] ts_rd [NLINES];
  logic [7:0]  rb    [NLINES];
  logic [7:0]  tb    [NLINES];

  // reset asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  assign pmode = par_mode_e'(par_cfg);

  tmx_decode #(.NLINES(NLINES), .BASE(BASE)) u_dec (
    .addr (bus_addr),
    .hit  (hit),
    .line (line),
    .sel  (sel)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic       me;
    logic [7:0] chr;
    logic       odd;

    assign me = hit && (line == LW'(i));

    tmx_parity u_par (
      .raw  (rx_data[i*8 +: 8]),
      .mode (pmode),
      .chr  (chr),
      .odd  (odd)
    );

    tmx_line #(.DLY_W(DLY_W)) u_line (
      .clk      (clk),
      .rst_n    (rst_n_i),
      .we_rstat (bus_wr && me && (sel == SEL_RSTAT)),
      .we_tstat (bus_wr && me && (sel == SEL_TSTAT)),
      .we_tbuf  (bus_wr && me && (sel == SEL_TBUF)),
      .re_rstat (bus_rd && me && (sel == SEL_RSTAT)),
      .re_rbuf  (bus_rd && me && (sel == SEL_RBUF)),
      .wr_byte  (bus_byte),
      .wr_odd   (bus_addr[0]),
      .wdata    (bus_wdata),
      .rx_stb   (rx_stb[i]),
      .rx_chr   (chr),
      .rx_odd   (odd),
      .tx_dly   (tx_dly),
      .rstat_rd (rs_rd[i]),
      .rbuf     (rb[i]),
      .tstat_rd (ts_rd[i]),
      .tbuf     (tb[i]),
      .tx_stb   (tx_stb[i]),
      .rx_irq   (rx_irq[i]),
      .tx_irq   (tx_irq[i])
    );

    assign tx_data[i*8 +: 8] = tb[i];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && hit) begin
      case (sel)
        SEL_RSTAT: bus_rdata = rs_rd[line];
        SEL_RBUF:  bus_rdata = {8'h00, rb[line]};
        SEL_TSTAT: bus_rdata = ts_rd[line];
        default:   bus_rdata = {8'h00, tb[line]};
      endcase
    end
  end
endmodule

// File: rtl/tmx_chk.sv
module tmx_chk #(
  parameter int NLINES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [15:0]       bus_rdata,
  input logic [NLINES-1:0] rx_stb,
  input logic [NLINES-1:0] tx_stb,
  input logic [NLINES-1:0] rx_irq,
  input logic [NLINES-1:0] tx_irq
);
  // R1
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 16'h0000));

  // R2
  hole_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (bus_rdata[11] == 1'b0));

  // R4
  err_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (bus_rdata[15] == (|bus_rdata[14:12])));

  // R9
  tx_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_stb) |=> ((tx_stb & $past(tx_stb)) == '0));

  // R10
  rx_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rx_irq & ~$past(rx_irq))) |-> ($past(|rx_stb) || $past(bus_wr)));

  // R11
  tx_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(tx_irq & ~$past(tx_irq))) |-> ((|(tx_stb & tx_irq)) || $past(bus_wr)));
endmodule

bind term_mux_regs tmx_chk #(.NLINES(NLINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .rx_stb    (rx_stb),
  .tx_stb    (tx_stb),
  .rx_irq    (rx_irq),
  .tx_irq    (tx_irq)
);

// File: tb/term_mux_regs_bench.sv
module term_mux_regs_bench;
  localparam int NL = 16;
  localparam int DW = 8;

  localparam logic [1:0] OP_WRW = 2'd0;
  localparam logic [1:0] OP_WRB = 2'd1;
  localparam logic [1:0] OP_RD  = 2'd2;
  localparam logic [1:0] OP_RX  = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [15:0] data;
    logic [1:0]  par;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{OP_RD,  16'hFE10, 16'h0000, 2'd0, 16'h0000, 4'd12}, // R12 rx status
    '{OP_RD,  16'hFE14, 16'h0000, 2'd0, 16'h0080, 4'd12}, // R12 tx status
    '{OP_RD,  16'hFE16, 16'h0000, 2'd0, 16'h0000, 4'd12}, // R12 tx buffer
    '{OP_WRW, 16'hFE10, 16'hFFFF, 2'd0, 16'h0000, 4'd3},
    '{OP_RD,  16'hFE10, 16'h0000, 2'd0, 16'h075B, 4'd3},  // R3 write mask
    '{OP_WRW, 16'hFE10, 16'h0000, 2'd0, 16'h0000, 4'd3},
    '{OP_RX,  16'h0002, 16'h0041, 2'd0, 16'h0000, 4'd5},
    '{OP_RD,  16'hFE12, 16'h0000, 2'd0, 16'h0041, 4'd8},  // R8 stored byte
    '{OP_RX,  16'h0002, 16'h0043, 2'd0, 16'h0000, 4'd5},
    '{OP_RD,  16'hFE10, 16'h0000, 2'd0, 16'h90A0, 4'd5},  // R5 overrun, R7 odd, R4 summary
    '{OP_RD,  16'hFE10, 16'h0000, 2'd0, 16'h0020, 4'd4},  // R4 sticky cleared
    '{OP_RX,  16'h0002, 16'h0041, 2'd1, 16'h0000, 4'd6},
    '{OP_RD,  16'hFE12, 16'h0000, 2'd0, 16'h00C1, 4'd6},  // R6 odd insertion
    '{OP_RX,  16'h0002, 16'h00C3, 2'd2, 16'h0000, 4'd6},
    '{OP_RD,  16'hFE12, 16'h0000, 2'd0, 16'h00C3, 4'd6},  // R6 even insertion
    '{OP_RD,  16'hFE10, 16'h0000, 2'd0, 16'h9080, 4'd5},  // R5 overrun, R7 even
    '{OP_WRB, 16'hFE11, 16'h0007, 2'd0, 16'h0000, 4'd3},
    '{OP_WRB, 16'hFE10, 16'h005B, 2'd0, 16'h0000, 4'd3},
    '{OP_RD,  16'hFE10, 16'h0000, 2'd0, 16'h075B, 4'd3},  // R3 byte merge
    '{OP_WRB, 16'hFE15, 16'h00FF, 2'd0, 16'h0000, 4'd3},
    '{OP_RD,  16'hFE14, 16'h0000, 2'd0, 16'h0180, 4'd3},  // R3 high byte merge
    '{OP_WRW, 16'hFE14, 16'hFFFF, 2'd0, 16'h0000, 4'd2},
    '{OP_RD,  16'hFE14, 16'h0000, 2'd0, 16'h01DD, 4'd2},  // R2 tx read mask
    '{OP_RD,  16'hFE28, 16'h0000, 2'd0, 16'h0000, 4'd1},  // R1 other line untouched
    '{OP_WRW, 16'hFE12, 16'h1234, 2'd0, 16'h0000, 4'd8},
    '{OP_RD,  16'hFE12, 16'h0000, 2'd0, 16'h00C3, 4'd8},  // R8 write ignored
    '{OP_RD,  16'hFE80, 16'h0000, 2'd0, 16'h0000, 4'd1},  // R1 outside window
    '{OP_RX,  16'h0002, 16'h0085, 2'd3, 16'h0000, 4'd6},
    '{OP_RD,  16'hFE12, 16'h0000, 2'd0, 16'h0085, 4'd6},  // R6 pass mode
    '{OP_RD,  16'hFE10, 16'h0000, 2'd0, 16'h07FB, 4'd7}   // R7 parity flag
  };

  logic               clk;
  logic               rst_n;
  logic [15:0]        bus_addr;
  logic               bus_wr;
  logic               bus_byte;
  logic               bus_rd;
  logic [15:0]        bus_wdata;
  logic [15:0]        bus_rdata;
  logic [NL-1:0]      rx_stb;
  logic [NL*8-1:0]    rx_data;
  logic [1:0]         par_cfg;
  logic [DW-1:0]      tx_dly;
  logic [NL-1:0]      tx_stb;
  logic [NL*8-1:0]    tx_data;
  logic [NL-1:0]      rx_irq;
  logic [NL-1:0]      tx_irq;

  int  checks;
  int  errors;
  bit  finished;

  term_mux_regs #(.NLINES(NL), .BASE(16'hFE00), .DLY_W(DW)) u_term_mux_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_byte  (bus_byte),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rx_stb    (rx_stb),
    .rx_data   (rx_data),
    .par_cfg   (par_cfg),
    .tx_dly    (tx_dly),
    .tx_stb    (tx_stb),
    .tx_data   (tx_data),
    .rx_irq    (rx_irq),
    .tx_irq    (tx_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] kind, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] p, output logic [15:0] rv);
    @(negedge clk);
    par_cfg = p;
    case (kind)
      OP_WRW: begin bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_byte = 1'b0; end
      OP_WRB: begin bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_byte = 1'b1; end
      OP_RD:  begin bus_addr = a; bus_rd = 1'b1; end
      default: begin rx_stb[a[3:0]] = 1'b1; rx_data[a[3:0]*8 +: 8] = d[7:0]; end
    endcase
    #1 rv = bus_rdata;
    @(posedge clk);
    #1;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_byte = 1'b0; rx_stb = '0;
  endtask

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rv;
    checks = 0; errors = 0; finished = 1'b0;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_byte = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; rx_stb = '0; rx_data = '0; par_cfg = 2'd0; tx_dly = 8'd3;
    settle(3);
    @(negedge clk); rst_n = 1'b1;
    settle(4);
    chk("R12 irq after reset", {tx_irq, rx_irq}, 32'h0);
    chk("R12 strobe after reset", tx_stb, 32'h0);

    for (int k = 0; k < NV; k++) begin
      do_op(VEC[k].op, VEC[k].addr, VEC[k].data, VEC[k].par, rv);
      if (VEC[k].op == OP_RD) begin
        chk($sformatf("R%0d vector %0d", VEC[k].req, k), rv, VEC[k].exp);
      end
    end

    // R10 receive interrupt request
    chk("R10 idle", rx_irq[2], 1'b0);
    do_op(OP_RX, 16'h0002, 16'h0010, 2'd0, rv);
    chk("R10 set on arrival", rx_irq, 32'h0004);
    do_op(OP_WRW, 16'hFE10, 16'h0000, 2'd0, rv);
    chk("R10 cleared by enable off", rx_irq[2], 1'b0);
    do_op(OP_WRW, 16'hFE10, 16'h0040, 2'd0, rv);
    chk("R10 set by enable with done", rx_irq[2], 1'b1);
    do_op(OP_RD, 16'hFE12, 16'h0000, 2'd0, rv);
    chk("R8 read after enable", rv, 16'h0010);
    chk("R10 cleared by buffer read", rx_irq[2], 1'b0);

    // R9 and R11 transmit path
    chk("R11 set by enable with done", tx_irq, 32'h0004);
    do_op(OP_WRW, 16'hFE16, 16'h0155, 2'd0, rv);
    chk("R11 cleared by buffer write", tx_irq[2], 1'b0);
    chk("R9 no strobe at write", tx_stb, 32'h0);
    for (int k = 1; k <= 3; k++) begin
      @(posedge clk); #1;
      chk($sformatf("R9 no strobe while counting %0d", k), tx_stb, 32'h0);
    end
    @(posedge clk); #1;
    chk("R9 strobe on expiry", tx_stb, 32'h0004);
    chk("R9 transmit byte", tx_data[23:16], 8'h55);
    chk("R11 set on expiry", tx_irq[2], 1'b1);
    @(posedge clk); #1;
    chk("R9 strobe single cycle", tx_stb, 32'h0);
    do_op(OP_WRB, 16'hFE17, 16'h00AA, 2'd0, rv);
    do_op(OP_RD, 16'hFE14, 16'h0000, 2'd0, rv);
    chk("R9 done cleared during delay", rv, 16'h015D);
    settle(6);
    do_op(OP_RD, 16'hFE16, 16'h0000, 2'd0, rv);
    chk("R9 odd byte write not stored", rv, 16'h0055);
    do_op(OP_RD, 16'hFE14, 16'h0000, 2'd0, rv);
    chk("R9 done back after delay", rv, 16'h01DD);

    // R12 reset in the middle of activity
    @(negedge clk); rst_n = 1'b0;
    settle(2);
    @(negedge clk); rst_n = 1'b1;
    settle(4);
    chk("R12 irq cleared", {tx_irq, rx_irq}, 32'h0);
    do_op(OP_RD, 16'hFE10, 16'h0000, 2'd0, rv);
    chk("R12 rx status", rv, 16'h0000);
    do_op(OP_RD, 16'hFE12, 16'h0000, 2'd0, rv);
    chk("R12 rx buffer", rv, 16'h0000);
    do_op(OP_RD, 16'hFE14, 16'h0000, 2'd0, rv);
    chk("R12 tx status", rv, 16'h0080);
    do_op(OP_RD, 16'hFE16, 16'h0000, 2'd0, rv);
    chk("R12 tx buffer", rv, 16'h0000);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule